// File: doc/BRIEF.md
# Two-Level Eight-Source Interrupt Controller

This block arbitrates interrupt requests from eight sources on behalf of a processor core: four active-low external pins, three timer overflow flags and one serial port flag. Each source is gated by its own enable bit and by a global enable, and each carries one priority bit that places it in the high or the low level. Among the enabled requests the controller picks a single winner, raises a request line to the core and presents the winner's source index and its fixed vector address.

The external pins pass through a two-flop synchroniser. Each pin can be set to trigger on a low level or on a falling edge. In edge mode the pending flag is latched by hardware and cleared by hardware when the core accepts that source. In level mode the flag simply mirrors the inverted synchronised pin. The two upper external sources are configured through a bit-addressable control register that also holds their enable and priority bits. A two-entry in-service record lets a high-priority request nest over a running low-priority routine. A return strobe from the core releases the highest active level.

Top module: `irq8_ctrl`

## Requirements
- R1: The vector address is 8*i+3, where i is the source index: 0 external 0 (03H), 1 timer 0 (0BH), 2 external 1 (13H), 3 timer 1 (1BH), 4 serial (23H), 5 timer 2 (2BH), 6 external 2 (33H), 7 external 3 (3BH); `src_o` carries i.
- R2: Among enabled requests of the same priority level, the lowest source index wins.
- R3: Any enabled high-priority request wins over every low-priority request, whatever their indices.
- R4: With `en_i[7]` (global enable) low, `irq_o` stays low.
- R5: Sources 0 to 5 are enabled by `en_i[0]` to `en_i[5]`; source 6 by control bit 2 and source 7 by control bit 6. The priority of sources 0 to 5 is `pri_i[0..5]`; of source 6 control bit 3, of source 7 control bit 7.
- R6: Control register bits 7..0 are: prio3, enable3, flag3, edge3, prio2, enable2, flag2, edge2. A bit write (`bit_wr_i`, `bit_idx_i`, `bit_val_i`) changes only the addressed bit; a byte write loads all of them.
- R7: With its edge bit set, a 1-to-0 transition of a synchronised external pin sets that source's flag; the flag stays set after the pin returns high and is cleared when the core accepts that source.
- R8: With its edge bit clear, an external source's flag equals the inverted synchronised pin and is not held after the pin returns high.
- R9: While a low-level routine is in service, only high-priority requests are presented; while a high-level routine is in service, no request is presented.
- R10: A pulse on `reti_i` releases the high in-service level if it is active, otherwise the low one.
- R11: After reset the control register reads 0, no flag is pending, nothing is in service and `irq_o` is low.
- R12: `trig_i[0]` and `trig_i[1]` select edge (1) or level (0) triggering for external 0 and external 1, with the same flag behaviour as R7 and R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_n_i | input | 4 | External interrupt pins, active low, index 0..3 = external 0..3 |
| per_flag_i | input | 4 | Peripheral flags: bit0 timer 0, bit1 timer 1, bit2 serial, bit3 timer 2 |
| en_i | input | 8 | Bit 7 global enable, bits 0..5 enables of sources 0..5 |
| pri_i | input | 6 | Priority bits of sources 0..5 (1 = high) |
| trig_i | input | 2 | Edge select for external 0 and 1 |
| ctl_wr_i | input | 1 | Byte write strobe of the control register |
| ctl_wdata_i | input | 8 | Byte write data |
| bit_wr_i | input | 1 | Single-bit write strobe |
| bit_idx_i | input | 3 | Bit position for a single-bit write |
| bit_val_i | input | 1 | Value for a single-bit write |
| ctl_rdata_o | output | 8 | Control register read value including live flags |
| ack_i | input | 1 | Core accepts the presented request |
| reti_i | input | 1 | Return-from-interrupt strobe |
| irq_o | output | 1 | Request to the core |
| src_o | output | 3 | Winning source index |
| vector_o | output | 8 | Winning vector address |
| pending_o | output | 8 | Raw request flags by source index |

## Verification
Every cycle the assertions check that a presented request carries a vector aligned to its source index, that it comes from a pending source, that nothing is presented without the global enable or while a high-level routine runs, that a return strobe releases the high level, and that reset empties the in-service record. Polling order, priority override, the latching of edge flags against the transparency of level flags, clearing on acceptance, single-bit register writes and the full nest-and-return sequence depend on multi-cycle stimulus and are shown only by the bench's scenarios.

// File: rtl/irq8_pkg.sv
package irq8_pkg;

    localparam int N_SRC   = 8;
    localparam int IDX_W   = $clog2(N_SRC);
    localparam int N_EXT   = 4;
    localparam int N_PER   = 4;
    localparam int N_CLASSIC = 6;

    // control register bit positions (behaviour depends on them)
    localparam int CB_EDGE2 = 0;
    localparam int CB_FLAG2 = 1;
    localparam int CB_EN2   = 2;
    localparam int CB_PRI2  = 3;
    localparam int CB_EDGE3 = 4;
    localparam int CB_FLAG3 = 5;
    localparam int CB_EN3   = 6;
    localparam int CB_PRI3  = 7;

    // source indices in polling order
    localparam logic [IDX_W-1:0] SRC_EXT0 = 3'd0;
    localparam logic [IDX_W-1:0] SRC_EXT1 = 3'd2;
    localparam logic [IDX_W-1:0] SRC_EXT2 = 3'd6;
    localparam logic [IDX_W-1:0] SRC_EXT3 = 3'd7;

    typedef enum logic {LVL_LOW = 1'b0, LVL_HIGH = 1'b1} level_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        level_e           lvl;
    } grant_t;

    // lowest set index of a request vector
    function automatic logic [IDX_W-1:0] first_set(input logic [N_SRC-1:0] v);
        logic [IDX_W-1:0] r;
        r = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = IDX_W'(i);
        end
        return r;
    endfunction

    function automatic logic [7:0] vector_of(input logic [IDX_W-1:0] idx);
        return {2'b00, idx, 3'b011};
    endfunction

endpackage

// File: rtl/irq8_ext_detect.sv
module irq8_ext_detect
    import irq8_pkg::*;
#(
    parameter int N_CH        = N_EXT,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] pin_n,
    input  logic [N_CH-1:0] edge_mode,
    input  logic [N_CH-1:0] sw_we,
    input  logic [N_CH-1:0] sw_val,
    input  logic [N_CH-1:0] svc_clr,
    output logic [N_CH-1:0] flag
);

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [SYNC_STAGES-1:0] sync_q;
        logic                   prev_q;
        logic                   edge_flag_q;
        logic                   synced;
        logic                   fall;

        assign synced = sync_q[SYNC_STAGES-1];
        assign fall   = prev_q & ~synced;

        always_ff @(posedge clk) begin
            if (rst) begin
                sync_q <= '1;
                prev_q <= 1'b1;
            end else begin
                sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n[c]};
                prev_q <= synced;
            end
        end

        always_ff @(posedge clk) begin
            if (rst || !edge_mode[c]) begin
                edge_flag_q <= 1'b0;
            end else if (fall) begin
                edge_flag_q <= 1'b1;
            end else if (svc_clr[c]) begin
                edge_flag_q <= 1'b0;
            end else if (sw_we[c]) begin
                edge_flag_q <= sw_val[c];
            end
        end

        assign flag[c] = edge_mode[c] ? edge_flag_q : ~synced;
    end

endmodule

// File: rtl/irq8_arbiter.sv
module irq8_arbiter
    import irq8_pkg::*;
(
    input  logic [N_SRC-1:0] req,
    input  logic [N_SRC-1:0] en,
    input  logic [N_SRC-1:0] pri,
    input  logic             ins_hi,
    input  logic             ins_lo,
    output grant_t           grant
);

    logic [N_SRC-1:0] live;
    logic [N_SRC-1:0] hi_set;
    logic [N_SRC-1:0] lo_set;

    assign live   = req & en;
    assign hi_set = live & pri;
    assign lo_set = live & ~pri;

    always_comb begin
        grant = '{valid: 1'b0, idx: '0, lvl: LVL_LOW};
        if (!ins_hi) begin
            if (|hi_set) begin
                grant = '{valid: 1'b1, idx: first_set(hi_set), lvl: LVL_HIGH};
            end else if (!ins_lo && |lo_set) begin
                grant = '{valid: 1'b1, idx: first_set(lo_set), lvl: LVL_LOW};
            end
        end
    end

endmodule

// File: rtl/irq8_inservice.sv
module irq8_inservice
    import irq8_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  level_e push_lvl,
    input  logic   pop,
    output logic   ins_hi,
    output logic   ins_lo
);

    logic hi_q, lo_q;
    logic hi_after_pop, lo_after_pop;

    always_comb begin
        hi_after_pop = hi_q;
        lo_after_pop = lo_q;
        if (pop) begin
            if (hi_q) hi_after_pop = 1'b0;
            else      lo_after_pop = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= 1'b0;
            lo_q <= 1'b0;
        end else begin
            hi_q <= hi_after_pop | (push && push_lvl == LVL_HIGH);
            lo_q <= lo_after_pop | (push && push_lvl == LVL_LOW);
        end
    end

    assign ins_hi = hi_q;
    assign ins_lo = lo_q;

endmodule

// File: rtl/irq8_ctrl.sv
module irq8_ctrl
    import irq8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_EXT-1:0]     ext_n_i,
    input  logic [N_PER-1:0]     per_flag_i,
    input  logic [7:0]           en_i,
    input  logic [N_CLASSIC-1:0] pri_i,
    input  logic [1:0]           trig_i,
    input  logic                 ctl_wr_i,
    input  logic [7:0]           ctl_wdata_i,
    input  logic                 bit_wr_i,
    input  logic [2:0]           bit_idx_i,
    input  logic                 bit_val_i,
    output logic [7:0]           ctl_rdata_o,
    input  logic                 ack_i,
    input  logic                 reti_i,
    output logic                 irq_o,
    output logic [IDX_W-1:0]     src_o,
    output logic [7:0]           vector_o,
    output logic [N_SRC-1:0]     pending_o
);

    logic [7:0]       cfg_q;
    logic [N_EXT-1:0] edge_mode;
    logic [N_EXT-1:0] sw_we;
    logic [N_EXT-1:0] sw_val;
    logic [N_EXT-1:0] svc_clr;
    logic [N_EXT-1:0] ext_flag;
    logic [N_SRC-1:0] req_vec;
    logic [N_SRC-1:0] en_vec;
    logic [N_SRC-1:0] pri_vec;
    logic             ins_hi, ins_lo;
    logic             accept;
    grant_t           grant;

    // control register: flag bits live in the detector, not here
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (ctl_wr_i) begin
            cfg_q <= ctl_wdata_i & ~((8'd1 << CB_FLAG2) | (8'd1 << CB_FLAG3));
        end else if (bit_wr_i) begin
            if (32'(bit_idx_i) != CB_FLAG2 && 32'(bit_idx_i) != CB_FLAG3) begin
                cfg_q[bit_idx_i] <= bit_val_i;
            end
        end
    end

    always_comb begin
        sw_we  = '0;
        sw_val = '0;
        if (ctl_wr_i) begin
            sw_we[2]  = 1'b1;
            sw_we[3]  = 1'b1;
            sw_val[2] = ctl_wdata_i[CB_FLAG2];
            sw_val[3] = ctl_wdata_i[CB_FLAG3];
        end else if (bit_wr_i) begin
            if (32'(bit_idx_i) == CB_FLAG2) begin
                sw_we[2]  = 1'b1;
                sw_val[2] = bit_val_i;
            end
            if (32'(bit_idx_i) == CB_FLAG3) begin
                sw_we[3]  = 1'b1;
                sw_val[3] = bit_val_i;
            end
        end
    end

    assign edge_mode = {cfg_q[CB_EDGE3], cfg_q[CB_EDGE2], trig_i};

    assign accept     = ack_i & grant.valid;
    assign svc_clr[0] = accept && grant.idx == SRC_EXT0;
    assign svc_clr[1] = accept && grant.idx == SRC_EXT1;
    assign svc_clr[2] = accept && grant.idx == SRC_EXT2;
    assign svc_clr[3] = accept && grant.idx == SRC_EXT3;

    irq8_ext_detect #(
        .N_CH        (N_EXT),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_ext (
        .clk       (clk),
        .rst       (rst),
        .pin_n     (ext_n_i),
        .edge_mode (edge_mode),
        .sw_we     (sw_we),
        .sw_val    (sw_val),
        .svc_clr   (svc_clr),
        .flag      (ext_flag)
    );

    // polling order: ext0, t0, ext1, t1, serial, t2, ext2, ext3
    assign req_vec = {ext_flag[3], ext_flag[2], per_flag_i[3], per_flag_i[2],
                      per_flag_i[1], ext_flag[1], per_flag_i[0], ext_flag[0]};
    assign en_vec  = {cfg_q[CB_EN3], cfg_q[CB_EN2], en_i[N_CLASSIC-1:0]}
                     & {N_SRC{en_i[7]}};
    assign pri_vec = {cfg_q[CB_PRI3], cfg_q[CB_PRI2], pri_i};

    irq8_arbiter u_arb (
        .req    (req_vec),
        .en     (en_vec),
        .pri    (pri_vec),
        .ins_hi (ins_hi),
        .ins_lo (ins_lo),
        .grant  (grant)
    );

    irq8_inservice u_ins (
        .clk      (clk),
        .rst      (rst),
        .push     (accept),
        .push_lvl (grant.lvl),
        .pop      (reti_i),
        .ins_hi   (ins_hi),
        .ins_lo   (ins_lo)
    );

    always_comb begin
        ctl_rdata_o           = cfg_q;
        ctl_rdata_o[CB_FLAG2] = ext_flag[2];
        ctl_rdata_o[CB_FLAG3] = ext_flag[3];
    end

    assign irq_o     = grant.valid;
    assign src_o     = grant.idx;
    assign vector_o  = vector_of(grant.idx);
    assign pending_o = req_vec;

endmodule

// File: rtl/irq8_ctrl_chk.sv
module irq8_ctrl_chk
    import irq8_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [7:0]       en_i,
    input logic             ack_i,
    input logic             reti_i,
    input logic             irq_o,
    input logic [IDX_W-1:0] src_o,
    input logic [7:0]       vector_o,
    input logic [N_SRC-1:0] pending_o,
    input logic             ins_hi,
    input logic             ins_lo
);

    p_vec_align_r1: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (vector_o[2:0] == 3'b011 && vector_o[5:3] == src_o && vector_o[7:6] == 2'b00));

    p_global_gate_r4: assert property (@(posedge clk) disable iff (rst)
        !en_i[7] |-> !irq_o);

    p_src_pending_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> pending_o[src_o]);

    p_hi_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        ins_hi |-> !irq_o);

    p_pop_hi_r10: assert property (@(posedge clk) disable iff (rst)
        (reti_i && !ack_i && ins_hi) |=> !ins_hi);

    p_reset_empty_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ins_hi && !ins_lo));

endmodule

bind irq8_ctrl irq8_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_i),
    .ack_i     (ack_i),
    .reti_i    (reti_i),
    .irq_o     (irq_o),
    .src_o     (src_o),
    .vector_o  (vector_o),
    .pending_o (pending_o),
    .ins_hi    (ins_hi),
    .ins_lo    (ins_lo)
);

// File: tb/irq8_ctrl_tb.sv
module irq8_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ext_n_i = 4'hF;
    logic [3:0] per_flag_i = '0;
    logic [7:0] en_i = '0;
    logic [5:0] pri_i = '0;
    logic [1:0] trig_i = '0;
    logic       ctl_wr_i = 1'b0;
    logic [7:0] ctl_wdata_i = '0;
    logic       bit_wr_i = 1'b0;
    logic [2:0] bit_idx_i = '0;
    logic       bit_val_i = 1'b0;
    logic [7:0] ctl_rdata_o;
    logic       ack_i = 1'b0;
    logic       reti_i = 1'b0;
    logic       irq_o;
    logic [2:0] src_o;
    logic [7:0] vector_o;
    logic [7:0] pending_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq8_ctrl u_dut (
        .clk(clk), .rst(rst), .ext_n_i(ext_n_i), .per_flag_i(per_flag_i),
        .en_i(en_i), .pri_i(pri_i), .trig_i(trig_i),
        .ctl_wr_i(ctl_wr_i), .ctl_wdata_i(ctl_wdata_i),
        .bit_wr_i(bit_wr_i), .bit_idx_i(bit_idx_i), .bit_val_i(bit_val_i),
        .ctl_rdata_o(ctl_rdata_o), .ack_i(ack_i), .reti_i(reti_i),
        .irq_o(irq_o), .src_o(src_o), .vector_o(vector_o), .pending_o(pending_o)
    );

    typedef struct {
        bit         chk_irq;
        logic       irq;
        logic [2:0] src;
        bit         chk_rd;
        logic [7:0] rd;
        bit         chk_pend;
        logic [7:0] pend;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    // monitor: compares one expected item per falling edge
    always @(negedge clk) begin
        if (sb_q.size() != 0) begin
            exp_t e;
            e = sb_q.pop_front();
            if (e.chk_irq) begin
                n_checks++;
                if (irq_o !== e.irq || (e.irq && (src_o !== e.src ||
                    vector_o !== {2'b00, e.src, 3'b011}))) begin
                    n_fail++;
                    $display("FAIL %s: irq=%b src=%0d vec=%h expected irq=%b src=%0d vec=%h",
                             e.tag, irq_o, src_o, vector_o, e.irq, e.src, {2'b00, e.src, 3'b011});
                end
            end
            if (e.chk_rd) begin
                n_checks++;
                if (ctl_rdata_o !== e.rd) begin
                    n_fail++;
                    $display("FAIL %s: ctl=%h expected %h", e.tag, ctl_rdata_o, e.rd);
                end
            end
            if (e.chk_pend) begin
                n_checks++;
                if (pending_o !== e.pend) begin
                    n_fail++;
                    $display("FAIL %s: pending=%h expected %h", e.tag, pending_o, e.pend);
                end
            end
        end
    end

    task automatic push_exp(exp_t e);
        sb_q.push_back(e);
        @(posedge clk); #1;
    endtask

    task automatic exp_irq(logic irq, logic [2:0] src, string tag);
        exp_t e;
        e = '{chk_irq: 1, irq: irq, src: src, chk_rd: 0, rd: '0,
              chk_pend: 0, pend: '0, tag: tag};
        push_exp(e);
    endtask

    task automatic exp_rd(logic [7:0] rd, string tag);
        exp_t e;
        e = '{chk_irq: 0, irq: 1'b0, src: '0, chk_rd: 1, rd: rd,
              chk_pend: 0, pend: '0, tag: tag};
        push_exp(e);
    endtask

    task automatic exp_pend(logic [7:0] p, string tag);
        exp_t e;
        e = '{chk_irq: 0, irq: 1'b0, src: '0, chk_rd: 0, rd: '0,
              chk_pend: 1, pend: p, tag: tag};
        push_exp(e);
    endtask

    task automatic cycles(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bit_write(logic [2:0] idx, logic val);
        bit_wr_i = 1'b1; bit_idx_i = idx; bit_val_i = val;
        @(posedge clk); #1;
        bit_wr_i = 1'b0;
    endtask

    task automatic pulse_ack();
        ack_i = 1'b1;
        @(posedge clk); #1;
        ack_i = 1'b0;
    endtask

    task automatic pulse_reti();
        reti_i = 1'b1;
        @(posedge clk); #1;
        reti_i = 1'b0;
    endtask

    task automatic pulse_pin(int ch);
        ext_n_i[ch] = 1'b0;
        cycles(2);
        ext_n_i[ch] = 1'b1;
        cycles(4);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        cycles(3);
        rst = 1'b0;
        #0;
        // R11 reset state
        exp_irq(1'b0, 3'd0, "R11 no request after reset");
        exp_rd(8'h00, "R11 control register cleared");
        exp_pend(8'h00, "R11 no pending flags");

        // R1 timer 0 vector, R4 global gate
        per_flag_i = 4'b0001;
        en_i = 8'h02;
        cycles(1);
        exp_irq(1'b0, 3'd0, "R4 global enable low blocks");
        en_i = 8'h82;
        exp_irq(1'b1, 3'd1, "R1 timer 0 vector 0BH");

        // R2 polling order with all peripherals pending
        per_flag_i = 4'b1111;
        en_i = 8'hBF;
        exp_irq(1'b1, 3'd1, "R2 timer 0 first in order");
        en_i = 8'hBD;
        exp_irq(1'b1, 3'd3, "R2 timer 1 next in order");
        // R3 high priority on the last classic source
        pri_i = 6'b100000;
        exp_irq(1'b1, 3'd5, "R3 high priority timer 2 wins");
        pri_i = '0;
        per_flag_i = '0;
        en_i = 8'h80;

        // R5/R8 external 2 level mode
        ctl_wr_i = 1'b1; ctl_wdata_i = 8'h04;
        @(posedge clk); #1;
        ctl_wr_i = 1'b0;
        ext_n_i[2] = 1'b0;
        cycles(3);
        exp_irq(1'b1, 3'd6, "R5 external 2 via control enable, vector 33H");
        exp_rd(8'h06, "R8 level flag follows low pin");
        ext_n_i[2] = 1'b1;
        cycles(3);
        exp_rd(8'h04, "R8 level flag not held");
        exp_irq(1'b0, 3'd0, "R8 no request after pin release");

        // R6 single-bit writes
        bit_write(3'd4, 1'b1);
        bit_write(3'd6, 1'b1);
        exp_rd(8'h54, "R6 bit writes touch only addressed bits");

        // R7 external 3 edge mode
        pulse_pin(3);
        exp_rd(8'h74, "R7 edge flag latched after pin high");
        exp_irq(1'b1, 3'd7, "R7 external 3 vector 3BH");
        pulse_ack();   // low level now in service
        exp_rd(8'h54, "R7 edge flag cleared on acceptance");

        // R9 nesting
        en_i = 8'h82;
        per_flag_i = 4'b0001;
        exp_irq(1'b0, 3'd0, "R9 low request blocked by low in service");
        pri_i = 6'b000010;
        exp_irq(1'b1, 3'd1, "R9 high request nests over low");
        pulse_ack();
        exp_irq(1'b0, 3'd0, "R9 high in service blocks all");
        // R10 returns
        pulse_reti();
        exp_irq(1'b1, 3'd1, "R10 return releases high level");
        pri_i = '0;
        exp_irq(1'b0, 3'd0, "R10 low level still in service");
        pulse_reti();
        exp_irq(1'b1, 3'd1, "R10 second return releases low level");

        // R12 external 0 edge mode via trig_i
        per_flag_i = '0;
        en_i = 8'h81;
        trig_i = 2'b01;
        cycles(1);
        pulse_pin(0);
        exp_pend(8'h01, "R12 external 0 edge flag latched");
        exp_irq(1'b1, 3'd0, "R12 external 0 vector 03H");
        pulse_ack();
        exp_pend(8'h00, "R12 external 0 flag cleared on acceptance");

        cycles(2);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule